// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block is a 32-bit interval timer with three registers: a counter, a limit and a control word. Software programs them through a single-cycle register write port and reads them back on the same address bus. While the timer is enabled and the processor is not halted, the counter climbs by one every clock cycle. When an increment finds the counter equal to the limit, the counter returns to zero and a sticky pending flag is set. The interrupt output is that flag qualified by the interrupt-enable bit.

Reprogramming the limit and clearing the counter arms the next expiry. This supports both one-shot and periodic use. With the limit left at all ones and the interrupt disabled, the block runs as a free-running cycle counter that wraps around. Software acknowledges an expiry by writing the control register. That write can change only the enable and run bits, and it always clears the pending flag.

Top module: `tmr_unit`

## Requirements
- R1: After reset the counter reads 0, the limit reads 0xFFFFFFFF, the control register reads 0 and irq_o is low.
- R2: Address 0 selects the counter, address 1 the limit, address 2 control and address 3 always reads 0. rdata_o follows addr_i combinationally, and a write is visible from the next cycle.
- R3: The counter advances by one per cycle only while control bit 1 (run) is set and halt_i is low. Otherwise it holds its value.
- R4: When an increment occurs with the counter equal to the limit, the counter becomes 0 and control bit 3 (pending) is set on the same clock edge.
- R5: Pending is set on expiry whatever the state of control bit 0 (interrupt enable). irq_o equals pending AND interrupt enable.
- R6: A control write loads bits 0 and 1 from the write data and clears pending. Control bits 2 and 31:4 always read 0.
- R7: If an expiry coincides with a control write, pending ends up set, so the new expiry is not lost. The run bit used in that cycle is the value held before the write.
- R8: A counter write takes priority over an increment in the same cycle. No expiry occurs in that cycle, even if the old counter equalled the limit.
- R9: With the limit at 0xFFFFFFFF the counter wraps from 0xFFFFFFFF to 0 and sets pending.
- R10: Pending stays set until a control write or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Processor halted; pauses counting |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt, pending AND enable |

## Verification
Two functions can fall in the same cycle: the acknowledging control write and the expiry that sets pending. A counter write can also meet an expiry. The bench programs a small limit and steps the counter cycle by cycle until it equals the limit. It then issues the control write, or the counter write, on exactly the edge that would wrap. Afterwards it reads control and counter back: pending must be set after the collision with the control write, and the counter must hold the written value with pending clear after the collision with the counter write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT = 2'd0,
    REG_LIM = 2'd1,
    REG_CTL = 2'd2,
    REG_RSV = 2'd3
  } reg_sel_e;

  localparam int CTL_IE = 0;
  localparam int CTL_RUN = 1;
  localparam int CTL_PEND = 3;
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         cnt_we_i,
  input  logic         lim_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] lim_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LIM_RST = '1;

  logic [W-1:0] cnt_q, lim_q;
  logic         at_lim;

  assign at_lim = (cnt_q == lim_q);
  // software write to the counter beats the increment
  assign wrap_o = run_i & ~cnt_we_i & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (run_i) begin
      cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lim_q <= LIM_RST;
    else if (lim_we_i) lim_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0)); // R4
  AST_CNT_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q)); // R3
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cnt_we_i && !at_lim) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
endmodule

// File: rtl/tmr_csr.sv
module tmr_csr
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         halt_i,
  input  logic         ctl_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wrap_i,
  output logic         run_o,
  output logic         irq_o,
  output logic [W-1:0] ctl_o
);
  logic ie_q, run_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (ctl_we_i) begin
      ie_q  <= wdata_i[CTL_IE];
      run_q <= wdata_i[CTL_RUN];
    end
  end

  // a fresh expiry outranks the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (wrap_i) pend_q <= 1'b1;
    else if (ctl_we_i) pend_q <= 1'b0;
  end

  assign run_o = run_q & ~halt_i;
  assign irq_o = pend_q & ie_q;

  always_comb begin
    ctl_o = '0;
    ctl_o[CTL_IE] = ie_q;
    ctl_o[CTL_RUN] = run_q;
    ctl_o[CTL_PEND] = pend_q;
  end

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !wrap_i) |=> !pend_q); // R6
  AST_WRAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> pend_q); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ctl_we_i) |=> pend_q); // R10
  AST_HALT_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !run_o); // R3
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o
);
  logic         cnt_we, lim_we, ctl_we;
  logic         run, wrap;
  logic [W-1:0] cnt, lim, ctl;

  assign cnt_we = wr_en_i & (addr_i == REG_CNT);
  assign lim_we = wr_en_i & (addr_i == REG_LIM);
  assign ctl_we = wr_en_i & (addr_i == REG_CTL);

  tmr_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .cnt_we_i (cnt_we),
    .lim_we_i (lim_we),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .lim_o    (lim),
    .wrap_o   (wrap)
  );

  tmr_csr #(.W(W)) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt_i),
    .ctl_we_i (ctl_we),
    .wdata_i  (wdata_i),
    .wrap_i   (wrap),
    .run_o    (run),
    .irq_o    (irq_o),
    .ctl_o    (ctl)
  );

  always_comb begin
    unique case (addr_i)
      REG_CNT: rdata_o = cnt;
      REG_LIM: rdata_o = lim;
      REG_CTL: rdata_o = ctl;
      default: rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl[CTL_PEND] && ctl[CTL_IE]); // R5
endmodule

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic        halt;
    logic [1:0]  raddr;
    logic [31:0] exp;
    logic        irq;
  } vec_t;

  localparam int NV = 24;
  // addresses: 0 count, 1 limit, 2 control; control bits 0 ie, 1 run, 3 pending
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 32'd3,        1'b0, 2'd1, 32'd3,   1'b0}, // R2 limit write
    '{1'b1, 2'd0, 32'd1,        1'b0, 2'd0, 32'd1,   1'b0}, // R2 count write
    '{1'b1, 2'd2, 32'd3,        1'b0, 2'd0, 32'd1,   1'b0}, // R3 old run bit used
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd2,   1'b0}, // R3
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd3,   1'b0}, // R3
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd2, 32'hB,   1'b1}, // R4 R5 expiry
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd1,   1'b1}, // R4 restart from 0
    '{1'b0, 2'd0, 32'd0,        1'b1, 2'd0, 32'd1,   1'b1}, // R3 halt
    '{1'b0, 2'd0, 32'd0,        1'b1, 2'd0, 32'd1,   1'b1}, // R10 sticky
    '{1'b1, 2'd2, 32'd3,        1'b1, 2'd2, 32'd3,   1'b0}, // R6 ack
    '{1'b1, 2'd0, 32'd0,        1'b0, 2'd0, 32'd0,   1'b0}, // R8 write beats inc
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd1,   1'b0}, // R3
    '{1'b1, 2'd2, 32'hFFFF_FFFE,1'b0, 2'd2, 32'd2,   1'b0}, // R6 masked bits
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd3,   1'b0}, // R3
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd2, 32'hA,   1'b0}, // R5 pend without ie
    '{1'b1, 2'd2, 32'd3,        1'b0, 2'd2, 32'd3,   1'b0}, // R6 ack
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd2,   1'b0}, // R3
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'd3,   1'b0}, // R3
    '{1'b1, 2'd2, 32'd3,        1'b0, 2'd2, 32'hB,   1'b1}, // R7 collision
    '{1'b1, 2'd2, 32'd1,        1'b0, 2'd2, 32'd1,   1'b0}, // R6 stop run
    '{1'b1, 2'd0, 32'd3,        1'b0, 2'd0, 32'd3,   1'b0}, // R3 stopped
    '{1'b1, 2'd2, 32'd3,        1'b0, 2'd2, 32'd3,   1'b0}, // R3 old run=0, no wrap
    '{1'b1, 2'd0, 32'h10,       1'b0, 2'd2, 32'd3,   1'b0}, // R8 no expiry
    '{1'b0, 2'd0, 32'd0,        1'b0, 2'd0, 32'h11,  1'b0}  // R8 continues
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        halt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_unit uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .halt_i  (halt_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d, input logic h);
    wr_en_i = wr; addr_i = a; wdata_i = d; halt_i = h;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; halt_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a);
    addr_i = a; #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en_i = 1'b0; halt_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    peek(2'd0); check("R1 count", rdata_o, 32'd0);
    peek(2'd1); check("R1 limit", rdata_o, 32'hFFFF_FFFF);
    peek(2'd2); check("R1 control", rdata_o, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].halt);
      peek(VEC[i].raddr);
      check($sformatf("R2-R10 vec %0d rdata", i), rdata_o, VEC[i].exp);
      check($sformatf("R5 vec %0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i].irq});
    end

    // R2 reserved address
    step(1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0);
    peek(2'd3); check("R2 reserved", rdata_o, 32'd0);

    // R9 free-running wrap at all-ones limit
    do_reset();
    step(1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0);
    step(1'b1, 2'd2, 32'd2, 1'b0);
    peek(2'd0); check("R9 count before", rdata_o, 32'hFFFF_FFFE);
    step(1'b0, 2'd0, 32'd0, 1'b0);
    peek(2'd0); check("R9 count max", rdata_o, 32'hFFFF_FFFF);
    step(1'b0, 2'd0, 32'd0, 1'b0);
    peek(2'd0); check("R9 count wrapped", rdata_o, 32'd0);
    peek(2'd2); check("R9 pending", rdata_o, 32'hA);
    check("R9 irq off", {31'd0, irq_o}, 32'd0);
    // R5 enabling afterwards raises irq from the held pending flag? no: write clears it
    step(1'b1, 2'd2, 32'd3, 1'b0);
    check("R6 ack then irq low", {31'd0, irq_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule